// File: doc/BRIEF.md
# Machine-Check Error Mask and Router

This block gathers up to 32 machine-check error sources into one request. Each source that exists in a given build has a sticky status bit, which captures the source whenever it fires, and an enable bit in a mask register. The combined request is the OR of every status bit whose enable is set. Software reads the status, mask and control words over a simple read/write register bus and clears status bits by writing ones to them.

While the processor core runs, the combined request drives the core's machine-check line. When the core is disabled, the request goes to an external pin instead. One control bit chooses that pin: either a dedicated machine-check output or a PCI interrupt-A line. All three request outputs are registered. A parameter vector lists which source positions exist. Positions that do not exist never latch, cannot be enabled, and read as zero.

Top module: `mchk_router`

## Requirements
- R1: After reset, status reads 0x00000000, mask reads the implemented-position vector (default 0xFFFF0F3F), control reads 0x00000000, and all three request outputs are low.
- R2: A source high at a clock edge sets its status bit (bit i for source i) at that edge whether or not its mask bit is set. Sources at unimplemented positions never set a bit, and those bits read as zero.
- R3: Writing the status word clears every status bit written with 1 and leaves bits written with 0 unchanged. A source that is high in the same cycle as the clear keeps its bit set.
- R4: Writing the mask word updates only implemented positions. Unimplemented mask bits ignore writes and read as zero. Mask bit 1 enables a source and mask bit 0 masks it.
- R5: Only bit 0 of the control word (the route bit) is writable. Its other bits ignore writes and read as zero.
- R6: With core_off low, core_mchk equals the OR of (status AND mask) one clock after the status or mask register changes, and pin_mchk and pci_inta are low.
- R7: With core_off high and route bit 0, pci_inta carries the request, and core_mchk and pin_mchk are low.
- R8: With core_off high and route bit 1, pin_mchk carries the request, and core_mchk and pci_inta are low.
- R9: A masked source that fires sets its status bit but produces no request on any output.
- R10: The register byte offsets are 0x40 (status), 0x44 (mask) and 0x48 (control). Any other offset reads as zero. Read data appears on bus_rdata one clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_src | input | 32 | Machine-check error sources, bit i is source i |
| core_off | input | 1 | High when the processor core is disabled |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| core_mchk | output | 1 | Machine-check request to the core |
| pin_mchk | output | 1 | Dedicated machine-check output pin |
| pci_inta | output | 1 | PCI interrupt-A request |

## Verification
The assertions assume that reset is held for at least one clock edge before it is released. They also assume that every input carries a defined 0 or 1 at each edge, because the sticky and stability checks compare against the previous cycle's values. The bench drives every input to a known value at time zero, keeps reset asserted for several edges, and changes stimulus only on falling edges. The bench also makes core_off and the source lines change only between register accesses. The one exception is the same-cycle clear case, where a source and a clear are driven together on purpose.

// File: rtl/mchk_pkg.sv
package mchk_pkg;
  localparam int unsigned NSRC   = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_MASK = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mchk_status.sv
module mchk_status #(
  parameter int unsigned N = 32,
  parameter logic [N-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] stat_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      always_ff @(posedge clk) begin
        if (rst)          stat_q[i] <= 1'b0;
        else if (src_i[i]) stat_q[i] <= 1'b1;
        else if (clr_i[i]) stat_q[i] <= 1'b0;
      end
    end else begin : g_rsvd
      assign stat_q[i] = 1'b0;
    end
  end

  assign status_o = stat_q;

  // R2
  latch_src_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(src_i) & IMPL) & ~stat_q) == '0));

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(stat_q) & ~$past(clr_i)) & ~stat_q) == '0));

  // R3
  clear_only_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((stat_q & ~$past(stat_q)) & ~$past(src_i)) == '0));
endmodule

// File: rtl/mchk_regs.sv
module mchk_regs
  import mchk_pkg::*;
#(
  parameter int unsigned N = 32,
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32,
  parameter logic [N-1:0] IMPL = '1,
  parameter logic [AW-1:0] STAT_OFS = 8'h40,
  parameter logic [AW-1:0] MASK_OFS = 8'h44,
  parameter logic [AW-1:0] CTRL_OFS = 8'h48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [N-1:0]  status_i,
  output logic [DW-1:0] rdata_o,
  output logic [N-1:0]  clr_o,
  output logic [N-1:0]  mask_o,
  output logic          route_o
);
  reg_sel_e     sel;
  logic         wr_stat, wr_mask, wr_ctrl, rd;
  logic [N-1:0] mask_q;
  logic         route_q;
  logic [DW-1:0] rd_mux, rdata_q;

  always_comb begin
    if (addr_i == STAT_OFS)      sel = SEL_STAT;
    else if (addr_i == MASK_OFS) sel = SEL_MASK;
    else if (addr_i == CTRL_OFS) sel = SEL_CTRL;
    else                         sel = SEL_NONE;
  end

  assign wr_stat = en_i && we_i && (sel == SEL_STAT);
  assign wr_mask = en_i && we_i && (sel == SEL_MASK);
  assign wr_ctrl = en_i && we_i && (sel == SEL_CTRL);
  assign rd      = en_i && !we_i;

  assign clr_o = wr_stat ? (wdata_i[N-1:0] & IMPL) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= IMPL;
      route_q <= 1'b0;
    end else begin
      if (wr_mask) mask_q  <= wdata_i[N-1:0] & IMPL;
      if (wr_ctrl) route_q <= wdata_i[0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_STAT: rd_mux[N-1:0] = status_i;
      SEL_MASK: rd_mux[N-1:0] = mask_q;
      SEL_CTRL: rd_mux[0]     = route_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign mask_o  = mask_q;
  assign route_o = route_q;

  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_mask |=> $stable(mask_q));

  // R5
  route_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_ctrl |=> $stable(route_q));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata_q));
endmodule

// File: rtl/mchk_steer.sv
module mchk_steer #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] status_i,
  input  logic [N-1:0] mask_i,
  input  logic         route_i,
  input  logic         core_off_i,
  output logic         core_o,
  output logic         pin_o,
  output logic         pci_o
);
  logic req;
  logic core_q, pin_q, pci_q;

  assign req = |(status_i & mask_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      core_q <= 1'b0;
      pin_q  <= 1'b0;
      pci_q  <= 1'b0;
    end else begin
      core_q <= req && !core_off_i;
      pin_q  <= req && core_off_i && route_i;
      pci_q  <= req && core_off_i && !route_i;
    end
  end

  assign core_o = core_q;
  assign pin_o  = pin_q;
  assign pci_o  = pci_q;

  // R6
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({core_q, pin_q, pci_q}));

  // R6
  core_mode_pins_chk: assert property (@(posedge clk) disable iff (rst)
    !core_off_i |=> (!pin_q && !pci_q));

  // R9
  no_req_chk: assert property (@(posedge clk) disable iff (rst)
    ((status_i & mask_i) == '0) |=> !(core_q || pin_q || pci_q));

  // R7
  alt_mode_core_chk: assert property (@(posedge clk) disable iff (rst)
    core_off_i |=> !core_q);
endmodule

// File: rtl/mchk_router.sv
module mchk_router
  import mchk_pkg::*;
#(
  parameter logic [NSRC-1:0]   IMPL     = 32'hFFFF_0F3F,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h40,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h44,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   err_src,
  input  logic              core_off,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              core_mchk,
  output logic              pin_mchk,
  output logic              pci_inta
);
  logic [NSRC-1:0] status, clr, mask;
  logic            route;

  mchk_status #(.N(NSRC), .IMPL(IMPL)) u_status (
    .clk(clk), .rst(rst), .src_i(err_src), .clr_i(clr), .status_o(status)
  );

  mchk_regs #(
    .N(NSRC), .AW(ADDR_W), .DW(DATA_W), .IMPL(IMPL),
    .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS), .CTRL_OFS(CTRL_OFS)
  ) u_regs (
    .clk(clk), .rst(rst), .en_i(bus_en), .we_i(bus_we), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .status_i(status), .rdata_o(bus_rdata),
    .clr_o(clr), .mask_o(mask), .route_o(route)
  );

  mchk_steer #(.N(NSRC)) u_steer (
    .clk(clk), .rst(rst), .status_i(status), .mask_i(mask), .route_i(route),
    .core_off_i(core_off), .core_o(core_mchk), .pin_o(pin_mchk), .pci_o(pci_inta)
  );
endmodule

// File: tb/mchk_router_test.sv
`timescale 1ns/1ps
module mchk_router_test;
  localparam logic [31:0] IMPL = 32'hFFFF_0F3F;
  localparam logic [7:0] A_STAT = 8'h40, A_MASK = 8'h44, A_CTRL = 8'h48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] err_src = '0;
  logic core_off = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic core_mchk, pin_mchk, pci_inta;

  int total = 0;
  int bad = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  mchk_router uut (
    .clk(clk), .rst(rst), .err_src(err_src), .core_off(core_off),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .core_mchk(core_mchk), .pin_mchk(pin_mchk), .pci_inta(pci_inta)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] outs();
    return {29'd0, core_mchk, pin_mchk, pci_inta};
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic pulse_src(input logic [31:0] s);
    err_src = s;
    @(posedge clk); @(negedge clk);
    err_src = '0;
  endtask

  task automatic t_reset();
    check("R1 outputs", outs(), 32'd0);
    bus_read(A_STAT, rv); check("R1 status", rv, 32'd0);
    bus_read(A_MASK, rv); check("R1 mask", rv, IMPL);
    bus_read(A_CTRL, rv); check("R1 control", rv, 32'd0);
  endtask

  task automatic t_unmasked();
    pulse_src(32'h0000_0008);
    check("R6 no request before one clock", outs(), 32'd0);
    @(negedge clk);
    check("R6 core request", outs(), 32'b100);
    bus_read(A_STAT, rv); check("R2 status latched", rv, 32'h0000_0008);
    bus_write(A_STAT, 32'h0000_0008);
    bus_read(A_STAT, rv); check("R3 cleared", rv, 32'd0);
    check("R6 request dropped", outs(), 32'd0);
  endtask

  task automatic t_masked();
    bus_write(A_MASK, IMPL & ~32'h10);
    pulse_src(32'h0000_0010);
    @(negedge clk);
    check("R9 masked no request", outs(), 32'd0);
    bus_read(A_STAT, rv); check("R9 status still set", rv, 32'h0000_0010);
    bus_write(A_MASK, IMPL);
    check("R6 unmask not yet visible", outs(), 32'd0);
    @(negedge clk);
    check("R6 unmask request", outs(), 32'b100);
    bus_write(A_STAT, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R3 all cleared no request", outs(), 32'd0);
  endtask

  task automatic t_reserved();
    pulse_src(32'h0000_F0C0);
    @(negedge clk);
    bus_read(A_STAT, rv); check("R2 reserved sources ignored", rv, 32'd0);
    check("R2 no request from reserved", outs(), 32'd0);
    bus_write(A_MASK, 32'hFFFF_FFFF);
    bus_read(A_MASK, rv); check("R4 reserved mask bits zero", rv, IMPL);
    bus_write(A_MASK, 32'h0000_0000);
    bus_read(A_MASK, rv); check("R4 mask cleared", rv, 32'd0);
    bus_write(A_MASK, IMPL);
  endtask

  task automatic t_w1c();
    pulse_src(32'h0000_0003);
    bus_write(A_STAT, 32'h0000_0001);
    bus_read(A_STAT, rv); check("R3 clear one bit", rv, 32'h0000_0002);
    bus_write(A_STAT, 32'h0000_0000);
    bus_read(A_STAT, rv); check("R3 zero write no effect", rv, 32'h0000_0002);
    err_src = 32'h0000_0002;
    bus_write(A_STAT, 32'h0000_0002);
    err_src = '0;
    bus_read(A_STAT, rv); check("R3 source beats clear", rv, 32'h0000_0002);
    bus_write(A_STAT, 32'h0000_0002);
    bus_read(A_STAT, rv); check("R3 final clear", rv, 32'd0);
  endtask

  task automatic t_route();
    bus_write(A_CTRL, 32'hFFFF_FFFF);
    bus_read(A_CTRL, rv); check("R5 only route bit", rv, 32'd1);
    core_off = 1'b1;
    pulse_src(32'h0000_0001);
    @(negedge clk);
    check("R8 dedicated pin", outs(), 32'b010);
    bus_write(A_CTRL, 32'h0000_0000);
    @(negedge clk);
    check("R7 pci interrupt-A", outs(), 32'b001);
    core_off = 1'b0;
    @(negedge clk);
    check("R6 back to core", outs(), 32'b100);
    bus_write(A_STAT, 32'h0000_0001);
    @(negedge clk);
    check("R6 cleared", outs(), 32'd0);
    bus_write(8'h4C, 32'hFFFF_FFFF);
    bus_read(8'h4C, rv); check("R10 unmapped reads zero", rv, 32'd0);
    bus_read(A_MASK, rv); check("R10 mask offset intact", rv, IMPL);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_unmasked();
    t_masked();
    t_reserved();
    t_w1c();
    t_route();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule